// File: doc/BRIEF.md
# Endpoint Base Address Register Bank

This block holds the base address registers of a type 0 endpoint configuration header: six 32-bit slots, each fixed at elaboration time as unused, a 32-bit memory window, a 64-bit memory window that takes two adjacent slots, or an I/O window. Each window has a power-of-two size and, for memory, a prefetchable flag. Configuration software reads and writes the slots one dword at a time through a port with a slot index, write data and byte enables. It learns a window's size and type by writing all ones and reading back. It then writes the base address it assigns.

The bits below the window size are hardwired, so they report the window's type and size. An address decoder compares each incoming request address with the programmed bases. It raises a hit line for every window that claims the request. A window does not decode until software has given it a nonzero base.

Top module: `bar_bank`

## Requirements
- R1: Bit 0 of an implemented lower slot always reads 0 for a memory window and 1 for an I/O window. Bit 1 of an I/O slot always reads 0.
- R2: Bits 2:1 of a memory slot always read 2'b00 for a 32-bit window and 2'b10 for a 64-bit window.
- R3: Bit 3 of a memory slot always reads 1 when the window is prefetchable and 0 otherwise.
- R4: An unused slot reads 32'h0, ignores every write and never hits.
- R5: Bits below the window size, log2 of the size in bytes, are read-only. After a write of all ones, a memory or I/O slot reads back the size mask ORed with its hardwired type bits.
- R6: The slot that follows a 64-bit window holds address bits 63:32. All of its bits are writable, and its own hit line never asserts.
- R7: Byte enable bit b gates the write of data bits 8b+7:8b. A write with no byte enables changes nothing.
- R8: A memory window hits only for a memory request (`req_is_io`=0) whose address bits at and above the size equal the programmed base. A 32-bit window also requires address bits 63:32 to be zero.
- R9: An I/O window hits only for an I/O request (`req_is_io`=1) whose address matches the base at and above the size, with address bits 63:32 zero.
- R10: A window does not hit while its full programmed base (both slots for 64-bit) is zero.
- R11: Reset clears every stored base to zero. The slots then read only their hardwired type bits.
- R12: Slot kinds come from `SLOT_KIND`, two bits per slot, with slot i at bits 2i+1:2i: 0 unused, 1 32-bit memory, 2 64-bit memory, 3 I/O. `SLOT_SIZE` gives log2 of the size, six bits per slot. `SLOT_PREF` holds one prefetch bit per slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the slot at `cfg_idx` |
| cfg_idx | input | IDX_W (3) | Dword index of the slot being accessed |
| cfg_wdata | input | 32 | Write data |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_rdata | output | 32 | Read data of the slot at `cfg_idx` (combinational) |
| req_addr | input | ADDR_W (64) | Incoming request address |
| req_is_io | input | 1 | 1 for an I/O request, 0 for a memory request |
| bar_hit | output | NUM_SLOTS (6) | Per-slot hit lines |

## Verification
The bench uses the default parameters. Slot 0 is a 4 KiB non-prefetchable 32-bit window. Slots 1 and 2 form a 1 MiB prefetchable 64-bit window. Slot 3 is a 256-byte I/O window, slot 4 is unused, and slot 5 is a 64 KiB prefetchable 32-bit window. This one set brings every slot kind, both prefetch settings, the upper half of a 64-bit base and a never-programmed window within reach. Addresses just inside and just outside each window, requests of the wrong type and nonzero upper address bits on a 32-bit window then exercise the decode edges.

// File: rtl/bar_pkg.sv
package bar_pkg;

    typedef enum logic [1:0] {
        BK_NONE  = 2'd0,
        BK_MEM32 = 2'd1,
        BK_MEM64 = 2'd2,
        BK_IO    = 2'd3
    } bar_kind_e;

    typedef struct packed {
        bar_kind_e   kind;
        logic        upper;
        logic        pref;
        logic [5:0]  size_lg;
    } slot_cfg_t;

    function automatic logic [31:0] low_bits(input logic [5:0] lg);
        return (32'h1 << lg) - 32'h1;
    endfunction

    function automatic logic [31:0] writable_bits(input slot_cfg_t c);
        if (c.upper)             return 32'hFFFF_FFFF;
        else if (c.kind == BK_NONE) return 32'h0;
        else                     return ~low_bits(c.size_lg);
    endfunction

    function automatic logic [31:0] fixed_bits(input slot_cfg_t c);
        logic [31:0] v;
        v = 32'h0;
        if (!c.upper) begin
            case (c.kind)
                BK_IO:    v[0] = 1'b1;
                BK_MEM32: v[3] = c.pref;
                BK_MEM64: begin v[2:1] = 2'b10; v[3] = c.pref; end
                default:  v = 32'h0;
            endcase
        end
        return v;
    endfunction

endpackage

// File: rtl/bar_slot_reg.sv
module bar_slot_reg
    import bar_pkg::*;
#(
    parameter logic [31:0] WMASK = 32'h0,
    parameter logic [31:0] FIXED = 32'h0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    input  logic [3:0]  be,
    output logic [31:0] base_q,
    output logic [31:0] rdata
);
    localparam int NBYTES = 4;

    logic [31:0] store_q;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)
                store_q[8*b +: 8] <= 8'h0;
            else if (wr_en && be[b])
                store_q[8*b +: 8] <= wdata[8*b +: 8] & WMASK[8*b +: 8];
        end
    end

    assign base_q = store_q;
    assign rdata  = (store_q & WMASK) | FIXED;
endmodule

// File: rtl/bar_match.sv
module bar_match
    import bar_pkg::*;
#(
    parameter int          ADDR_W = 64,
    parameter slot_cfg_t   CFG    = '0
) (
    input  logic [31:0]       base_lo,
    input  logic [31:0]       base_hi,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_is_io,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] ONE_A = {{(ADDR_W-1){1'b0}}, 1'b1};
    localparam logic [ADDR_W-1:0] AMASK = ~((ONE_A << CFG.size_lg) - ONE_A);

    logic [ADDR_W-1:0] base_full;
    logic              kind_ok;
    logic              base_set;

    always_comb begin
        base_full = '0;
        base_full[31:0] = base_lo & ~low_bits(CFG.size_lg);
        if (CFG.kind == BK_MEM64 && ADDR_W > 32)
            base_full[ADDR_W-1:32] = base_hi[ADDR_W-33:0];
        base_set = (base_full != '0);
        case (CFG.kind)
            BK_MEM32, BK_MEM64: kind_ok = !req_is_io;
            BK_IO:              kind_ok = req_is_io;
            default:            kind_ok = 1'b0;
        endcase
        hit = !CFG.upper && kind_ok && base_set &&
              ((req_addr & AMASK) == (base_full & AMASK));
    end
endmodule

// File: rtl/bar_bank.sv
module bar_bank
    import bar_pkg::*;
#(
    parameter int                       NUM_SLOTS = 6,
    parameter int                       ADDR_W    = 64,
    parameter logic [2*NUM_SLOTS-1:0]   SLOT_KIND = 12'b01_00_11_00_10_01,
    parameter logic [6*NUM_SLOTS-1:0]   SLOT_SIZE = {6'd16, 6'd0, 6'd8, 6'd0, 6'd20, 6'd12},
    parameter logic [NUM_SLOTS-1:0]     SLOT_PREF = 6'b100010,
    localparam int                      IDX_W     = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_wr,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  logic [31:0]          cfg_wdata,
    input  logic [3:0]           cfg_be,
    output logic [31:0]          cfg_rdata,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 req_is_io,
    output logic [NUM_SLOTS-1:0] bar_hit
);
    function automatic slot_cfg_t cfg_of(input int s);
        slot_cfg_t c;
        c.kind    = bar_kind_e'(SLOT_KIND[2*s +: 2]);
        c.upper   = (s > 0) && (SLOT_KIND[2*(s-1) +: 2] == 2'(BK_MEM64));
        c.pref    = SLOT_PREF[s];
        c.size_lg = SLOT_SIZE[6*s +: 6];
        return c;
    endfunction

    logic [31:0] base_arr  [NUM_SLOTS];
    logic [31:0] rdata_arr [NUM_SLOTS];

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        localparam slot_cfg_t CFG = cfg_of(i);
        logic [31:0] hi_word;

        bar_slot_reg #(
            .WMASK (writable_bits(CFG)),
            .FIXED (fixed_bits(CFG))
        ) u_reg (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (cfg_wr && (cfg_idx == IDX_W'(i))),
            .wdata  (cfg_wdata),
            .be     (cfg_be),
            .base_q (base_arr[i]),
            .rdata  (rdata_arr[i])
        );

        if (i + 1 < NUM_SLOTS) begin : g_hi
            assign hi_word = base_arr[i+1];
        end else begin : g_nohi
            assign hi_word = 32'h0;
        end

        bar_match #(
            .ADDR_W (ADDR_W),
            .CFG    (CFG)
        ) u_match (
            .base_lo   (base_arr[i]),
            .base_hi   (hi_word),
            .req_addr  (req_addr),
            .req_is_io (req_is_io),
            .hit       (bar_hit[i])
        );
    end

    always_comb begin
        cfg_rdata = 32'h0;
        for (int k = 0; k < NUM_SLOTS; k++)
            if (cfg_idx == IDX_W'(k))
                cfg_rdata = rdata_arr[k];
    end
endmodule

// File: rtl/bar_bank_chk.sv
module bar_bank_chk
    import bar_pkg::*;
#(
    parameter int                     NUM_SLOTS = 6,
    parameter int                     ADDR_W    = 64,
    parameter logic [2*NUM_SLOTS-1:0] SLOT_KIND = '0,
    parameter logic [NUM_SLOTS-1:0]   SLOT_PREF = '0,
    parameter int                     IDX_W     = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cfg_wr,
    input logic [IDX_W-1:0]     cfg_idx,
    input logic [3:0]           cfg_be,
    input logic [31:0]          cfg_rdata,
    input logic                 req_is_io,
    input logic [NUM_SLOTS-1:0] bar_hit
);
    AST_EMPTY_WRITE_NOP: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_be == 4'h0) |=>
            (cfg_idx != $past(cfg_idx) || cfg_rdata == $past(cfg_rdata))); // R7

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_chk
        localparam logic [1:0] KIND  = SLOT_KIND[2*i +: 2];
        localparam bit         UPPER = (i > 0) && (SLOT_KIND[2*((i > 0) ? i-1 : 0) +: 2] == 2'd2);

        if (UPPER) begin : g_up
            AST_UPPER_NO_HIT: assert property (@(posedge clk) disable iff (rst)
                !bar_hit[i]); // R6
        end else if (KIND == 2'd0) begin : g_none
            AST_UNUSED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
                (cfg_idx == IDX_W'(i)) |-> (cfg_rdata == 32'h0)); // R4
            AST_UNUSED_NO_HIT: assert property (@(posedge clk) disable iff (rst)
                !bar_hit[i]); // R4
        end else if (KIND == 2'd3) begin : g_io
            AST_IO_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
                (cfg_idx == IDX_W'(i)) |-> (cfg_rdata[1:0] == 2'b01)); // R1
            AST_IO_HIT_TYPE: assert property (@(posedge clk) disable iff (rst)
                bar_hit[i] |-> req_is_io); // R9
        end else begin : g_mem
            AST_MEM_BIT0: assert property (@(posedge clk) disable iff (rst)
                (cfg_idx == IDX_W'(i)) |-> !cfg_rdata[0]); // R1
            AST_MEM_WIDTH_BITS: assert property (@(posedge clk) disable iff (rst)
                (cfg_idx == IDX_W'(i)) |->
                    (cfg_rdata[2:1] == ((KIND == 2'd2) ? 2'b10 : 2'b00))); // R2
            AST_MEM_PREF_BIT: assert property (@(posedge clk) disable iff (rst)
                (cfg_idx == IDX_W'(i)) |-> (cfg_rdata[3] == SLOT_PREF[i])); // R3
            AST_MEM_HIT_TYPE: assert property (@(posedge clk) disable iff (rst)
                bar_hit[i] |-> !req_is_io); // R8
        end
    end
endmodule

bind bar_bank bar_bank_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .ADDR_W    (ADDR_W),
    .SLOT_KIND (SLOT_KIND),
    .SLOT_PREF (SLOT_PREF),
    .IDX_W     (IDX_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .cfg_idx   (cfg_idx),
    .cfg_be    (cfg_be),
    .cfg_rdata (cfg_rdata),
    .req_is_io (req_is_io),
    .bar_hit   (bar_hit)
);

// File: tb/bar_bank_bench.sv
module bar_bank_bench;
    localparam int NS = 6;
    localparam int AW = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_wr = 1'b0;
    logic [2:0]    cfg_idx = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [3:0]    cfg_be = '0;
    logic [31:0]   cfg_rdata;
    logic [AW-1:0] req_addr = '0;
    logic          req_is_io = 1'b0;
    logic [NS-1:0] bar_hit;

    bar_bank u_bar_bank (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_be(cfg_be), .cfg_rdata(cfg_rdata),
        .req_addr(req_addr), .req_is_io(req_is_io), .bar_hit(bar_hit)
    );

    always #10 clk = ~clk;

    typedef struct {
        bit          is_hit;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t queue_q[$];
    event  ev_sample;
    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    initial begin : monitor
        forever begin
            @(ev_sample);
            while (queue_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = queue_q.pop_front();
                act = it.is_hit ? {26'h0, bar_hit} : cfg_rdata;
                n_run++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
                end
            end
        end
    end

    task automatic cfg_write(input int idx, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_idx = 3'(idx); cfg_wdata = d; cfg_be = be;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = 4'h0;
    endtask

    task automatic check_read(input int idx, input logic [31:0] exp, input string req);
        item_t it;
        @(negedge clk);
        cfg_idx = 3'(idx);
        it.is_hit = 1'b0; it.exp = exp; it.req = req;
        queue_q.push_back(it);
        #1 -> ev_sample;
    endtask

    task automatic check_hit(input logic [AW-1:0] a, input logic io,
                             input logic [NS-1:0] exp, input string req);
        item_t it;
        @(negedge clk);
        req_addr = a; req_is_io = io;
        it.is_hit = 1'b1; it.exp = {26'h0, exp}; it.req = req;
        queue_q.push_back(it);
        #1 -> ev_sample;
    endtask

    initial begin : watchdog
        #(20 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11 reset values; R1 R2 R3 type bits
        check_read(0, 32'h0000_0000, "R11 slot0 reset");
        check_read(1, 32'h0000_000C, "R2 R3 slot1 64-bit prefetchable");
        check_read(2, 32'h0000_0000, "R11 slot2 upper reset");
        check_read(3, 32'h0000_0001, "R1 slot3 io bit");
        check_read(5, 32'h0000_0008, "R3 slot5 prefetchable");
        check_hit(64'h0, 1'b0, 6'b000000, "R10 no hit with zero bases");

        // R5 size discovery
        for (int s = 0; s < NS; s++) cfg_write(s, 32'hFFFF_FFFF, 4'hF);
        check_read(0, 32'hFFFF_F000, "R5 slot0 size 4K");
        check_read(1, 32'hFFF0_000C, "R5 slot1 size 1M");
        check_read(2, 32'hFFFF_FFFF, "R6 upper fully writable");
        check_read(3, 32'hFFFF_FF01, "R5 slot3 io size 256");
        check_read(4, 32'h0000_0000, "R4 unused ignores write");
        check_read(5, 32'hFFFF_0008, "R5 slot5 size 64K");

        // R7 byte enables
        cfg_write(0, 32'h0, 4'hF);
        cfg_write(0, 32'hAABB_CCDD, 4'b0101);
        check_read(0, 32'h00BB_0000, "R7 partial byte write");
        cfg_write(0, 32'h1234_5678, 4'h0);
        check_read(0, 32'h00BB_0000, "R7 no byte enables");

        // program bases
        cfg_write(0, 32'h8000_0000, 4'hF);
        cfg_write(1, 32'h0030_0000, 4'hF);
        cfg_write(2, 32'h0000_0002, 4'hF);
        cfg_write(3, 32'h0000_1200, 4'hF);
        cfg_write(5, 32'h0000_0000, 4'hF);
        check_read(3, 32'h0000_1201, "R1 io base readback");

        check_hit(64'h0000_0000_8000_0FFC, 1'b0, 6'b000001, "R8 slot0 top of window");
        check_hit(64'h0000_0000_8000_1000, 1'b0, 6'b000000, "R8 slot0 past window");
        check_hit(64'h0000_0001_8000_0000, 1'b0, 6'b000000, "R8 32-bit needs upper zero");
        check_hit(64'h0000_0000_8000_0000, 1'b1, 6'b000000, "R8 io request to memory window");
        check_hit(64'h0000_0002_003F_FFFF, 1'b0, 6'b000010, "R6 R8 64-bit window hit");
        check_hit(64'h0000_0002_0040_0000, 1'b0, 6'b000000, "R8 64-bit past window");
        check_hit(64'h0000_0000_0030_0000, 1'b0, 6'b000000, "R8 64-bit wrong upper");
        check_hit(64'h0000_0000_0000_12FF, 1'b1, 6'b001000, "R9 io window hit");
        check_hit(64'h0000_0000_0000_12FF, 1'b0, 6'b000000, "R9 memory request to io window");
        check_hit(64'h0000_0000_0000_0000, 1'b0, 6'b000000, "R10 slot5 zero base no hit");
        check_hit(64'h0000_0000_0000_1300, 1'b1, 6'b000000, "R9 io past window");

        // R12 kind map: slot4 unused, written and probed
        cfg_write(4, 32'h1234_5678, 4'hF);
        check_read(4, 32'h0000_0000, "R12 R4 slot4 unused");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule